// File: doc/BRIEF.md
# SPI Low-Power Mode Sequencer

This block decides when a serial peripheral may lose its clocks. It takes two kinds of request. The first is an external stop request from the chip's power manager. The second is a module-disable condition, raised either by a software bit or by a hardware doze signal that only counts while a doze-enable bit is set. From these it drives two clock enables: one for the serial engine logic and one for the register file. It also drives a stop acknowledge, a flag that says register access is blocked, and frozen copies of the peripheral's interrupt and DMA request lines.

A stop request is never honoured in the middle of a frame. If the serial engine reports a transfer in flight, the sequencer waits in a pending state until the engine reports a frame boundary, and only then gates the clocks. While stopped, both clock domains are gated and the interrupt and DMA outputs hold the values captured on the entry edge. Module disable is lighter. It gates only the serial engine logic, so the registers stay reachable and the request lines keep following their sources. When both a stop and a disable are asked for, stop wins.

No data stream crosses this block, so it has no valid/ready handshake: every pin is a plain level-sensitive control or status signal, sampled on the rising clock edge.

Top module: `spi_pwr_seq`

## Requirements
- R1: `stop_ack` rises in the first cycle that `pwr_state` reads STOPPED and stays high until `pwr_state` returns to RUN; it is low in every other state.
- R2: A stop request seen in RUN while `xfer_busy`=1 and `frame_done`=0 moves the state to STOP_PENDING. The state stays there while that holds, moves to STOPPED on the edge where `frame_done`=1 or `xfer_busy`=0, and returns to RUN if `stop_req` drops first.
- R3: In STOPPED, `reg_blocked`=1, `core_clk_en`=0 and `reg_clk_en`=0.
- R4: In STOPPED, `irq_out` and `dma_out` hold the `irq_in` and `dma_in` values sampled on the clock edge that entered STOPPED, whatever the inputs do afterwards. In every other state they follow their inputs combinationally.
- R5: With `stop_req`=0, `sw_disable`=1 in RUN moves the state to DISABLED on the next edge.
- R6: With `stop_req`=0, `doze_in`=1 and `doze_en`=1 in RUN moves the state to DISABLED. `doze_in`=1 with `doze_en`=0 leaves the state at RUN.
- R7: In DISABLED, `core_clk_en`=0, `reg_clk_en`=1 and `reg_blocked`=0.
- R8: The state leaves STOPPED for RUN on the first edge where `stop_req`=0. It leaves DISABLED for RUN on the first edge where neither disable source is active and `stop_req`=0.
- R9: When stop is requested in RUN or DISABLED at the same time as a disable condition, the stop path is taken. From DISABLED, a stop request goes straight to STOPPED.
- R10: `pwr_state` encodes RUN=0, STOP_PENDING=1, STOPPED=2 and DISABLED=3. After reset it reads RUN, with both clock enables high and `stop_ack` and `reg_blocked` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | External stop request (level) |
| sw_disable | input | 1 | Software module-disable bit |
| doze_en | input | 1 | Enable for the hardware doze source |
| doze_in | input | 1 | Hardware doze signal |
| xfer_busy | input | 1 | Serial engine has a transfer in flight |
| frame_done | input | 1 | Serial engine is at a frame boundary this cycle |
| irq_in | input | IRQ_W | Interrupt request lines from the peripheral |
| dma_in | input | DMA_W | DMA request lines from the peripheral |
| stop_ack | output | 1 | Stop acknowledged; clocks may be shut off |
| core_clk_en | output | 1 | Enable for the serial engine clock gate |
| reg_clk_en | output | 1 | Enable for the register file clock gate |
| reg_blocked | output | 1 | Register access is unavailable |
| irq_out | output | IRQ_W | Interrupt requests, frozen while stopped |
| dma_out | output | DMA_W | DMA requests, frozen while stopped |
| pwr_state | output | 2 | Current power state (encoding in R10) |

## Verification
The assertions take for granted that `frame_done` only means something while a transfer is in flight, and that the request inputs are synchronous, stable levels at each rising edge. They assume no particular ordering between the stop and disable sources. The bench changes every input only on the falling edge. It reaches each of the four states from reset and then applies all 64 combinations of the six control inputs from that state, so every transition, including simultaneous stop and disable, is exercised.

// File: rtl/spi_pwr_pkg.sv
package spi_pwr_pkg;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_PEND = 2'd1,
    PS_STOP = 2'd2,
    PS_DIS  = 2'd3
  } pwr_state_e;

  localparam int unsigned PWR_STATE_W = 2;

endpackage

// File: rtl/spi_pwr_cond.sv
module spi_pwr_cond (
  input  logic sw_disable,
  input  logic doze_en,
  input  logic doze_in,
  input  logic xfer_busy,
  input  logic frame_done,
  output logic dis_want,
  output logic at_boundary
);

  // The doze source only counts when its enable bit is set.
  always_comb begin
    dis_want    = sw_disable | (doze_en & doze_in);
    at_boundary = ~xfer_busy | frame_done;
  end

endmodule

// File: rtl/spi_pwr_fsm.sv
module spi_pwr_fsm
  import spi_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       dis_want,
  input  logic       at_boundary,
  output pwr_state_e state_q,
  output logic       enter_stop,
  output logic       stop_ack,
  output logic       core_clk_en,
  output logic       reg_clk_en,
  output logic       reg_blocked
);

  pwr_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN: begin
        if (stop_req)      state_d = at_boundary ? PS_STOP : PS_PEND;
        else if (dis_want) state_d = PS_DIS;
      end
      PS_PEND: begin
        if (!stop_req)        state_d = PS_RUN;
        else if (at_boundary) state_d = PS_STOP;
      end
      PS_STOP: begin
        if (!stop_req) state_d = PS_RUN;
      end
      PS_DIS: begin
        // Engine is already idle, so a stop needs no frame wait.
        if (stop_req)      state_d = PS_STOP;
        else if (!dis_want) state_d = PS_RUN;
      end
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_RUN;
    else        state_q <= state_d;
  end

  always_comb begin
    enter_stop  = (state_d == PS_STOP) && (state_q != PS_STOP);
    stop_ack    = (state_q == PS_STOP);
    reg_blocked = (state_q == PS_STOP);
    reg_clk_en  = (state_q != PS_STOP);
    core_clk_en = (state_q == PS_RUN) || (state_q == PS_PEND);
  end

  AST_ACK_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_ack) |-> $past(stop_req)); // R1
  AST_PEND_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_PEND && stop_req && !at_boundary) |=> (state_q == PS_PEND)); // R2
  AST_BLOCKED_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_blocked |-> (!core_clk_en && !reg_clk_en)); // R3
  AST_DIS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DIS && $past(state_q) != PS_DIS) |-> $past(dis_want && !stop_req)); // R5
  AST_DIS_REGS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DIS) |-> (reg_clk_en && !reg_blocked && !stop_ack)); // R7
  AST_STOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_STOP && !stop_req) |=> (state_q == PS_RUN)); // R8
  AST_STOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PS_STOP && stop_req) |=> (state_q != PS_DIS)); // R9

endmodule

// File: rtl/spi_pwr_hold.sv
module spi_pwr_hold #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         frozen,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (capture) held_q <= d;
  end

  always_comb q = frozen ? held_q : d;

  AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> $stable(q)); // R4
  AST_FROZEN_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !$past(frozen)) |-> (q == $past(d))); // R4

endmodule

// File: rtl/spi_pwr_seq.sv
module spi_pwr_seq
  import spi_pwr_pkg::*;
#(
  parameter int unsigned IRQ_W = 4,
  parameter int unsigned DMA_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stop_req,
  input  logic                   sw_disable,
  input  logic                   doze_en,
  input  logic                   doze_in,
  input  logic                   xfer_busy,
  input  logic                   frame_done,
  input  logic [IRQ_W-1:0]       irq_in,
  input  logic [DMA_W-1:0]       dma_in,
  output logic                   stop_ack,
  output logic                   core_clk_en,
  output logic                   reg_clk_en,
  output logic                   reg_blocked,
  output logic [IRQ_W-1:0]       irq_out,
  output logic [DMA_W-1:0]       dma_out,
  output logic [PWR_STATE_W-1:0] pwr_state
);

  logic       dis_want;
  logic       at_boundary;
  logic       enter_stop;
  pwr_state_e state_q;

  spi_pwr_cond cond_i (
    .sw_disable (sw_disable),
    .doze_en    (doze_en),
    .doze_in    (doze_in),
    .xfer_busy  (xfer_busy),
    .frame_done (frame_done),
    .dis_want   (dis_want),
    .at_boundary(at_boundary)
  );

  spi_pwr_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .dis_want   (dis_want),
    .at_boundary(at_boundary),
    .state_q    (state_q),
    .enter_stop (enter_stop),
    .stop_ack   (stop_ack),
    .core_clk_en(core_clk_en),
    .reg_clk_en (reg_clk_en),
    .reg_blocked(reg_blocked)
  );

  spi_pwr_hold #(.W(IRQ_W)) irq_hold_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(enter_stop),
    .frozen (stop_ack),
    .d      (irq_in),
    .q      (irq_out)
  );

  spi_pwr_hold #(.W(DMA_W)) dma_hold_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(enter_stop),
    .frozen (stop_ack),
    .d      (dma_in),
    .q      (dma_out)
  );

  always_comb pwr_state = state_q;

  AST_DOZE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && !stop_req && !sw_disable && !doze_en) |=> (pwr_state == 2'd0)); // R6

endmodule

// File: tb/spi_pwr_seq_tb_top.sv
module spi_pwr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int IRQ_W = 4;
  localparam int DMA_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, sw_disable = 1'b0, doze_en = 1'b0, doze_in = 1'b0;
  logic xfer_busy = 1'b0, frame_done = 1'b0;
  logic [IRQ_W-1:0] irq_in = '0;
  logic [DMA_W-1:0] dma_in = '0;
  logic stop_ack, core_clk_en, reg_clk_en, reg_blocked;
  logic [IRQ_W-1:0] irq_out;
  logic [DMA_W-1:0] dma_out;
  logic [1:0] pwr_state;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_pwr_seq #(.IRQ_W(IRQ_W), .DMA_W(DMA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .sw_disable(sw_disable),
    .doze_en(doze_en), .doze_in(doze_in), .xfer_busy(xfer_busy),
    .frame_done(frame_done), .irq_in(irq_in), .dma_in(dma_in),
    .stop_ack(stop_ack), .core_clk_en(core_clk_en), .reg_clk_en(reg_clk_en),
    .reg_blocked(reg_blocked), .irq_out(irq_out), .dma_out(dma_out),
    .pwr_state(pwr_state)
  );

  // Expected next state, written from R2, R5, R6, R8, R9 (0=RUN 1=PEND 2=STOP 3=DIS).
  function automatic logic [1:0] exp_next(input logic [1:0] s, input logic sr,
      input logic sw, input logic de, input logic di, input logic bz, input logic fd);
    logic dis = sw | (de & di);
    logic bnd = ~bz | fd;
    case (s)
      2'd0: return sr ? (bnd ? 2'd2 : 2'd1) : (dis ? 2'd3 : 2'd0);
      2'd1: return !sr ? 2'd0 : (bnd ? 2'd2 : 2'd1);
      2'd2: return sr ? 2'd2 : 2'd0;
      default: return sr ? 2'd2 : (dis ? 2'd3 : 2'd0);
    endcase
  endfunction

  // Expected {stop_ack, core_clk_en, reg_clk_en, reg_blocked} per state (R1, R3, R7, R10).
  function automatic logic [3:0] exp_outs(input logic [1:0] s);
    case (s)
      2'd2: return 4'b1001;
      2'd3: return 4'b0010;
      default: return 4'b0110;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    stop_req = 0; sw_disable = 0; doze_en = 0; doze_in = 0;
    xfer_busy = 0; frame_done = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] st;
    logic [1:0] ex;
    // R10: reset state.
    do_reset();
    check("R10 reset state", pwr_state, 2'd0);
    check("R10 reset outs", {stop_ack, core_clk_en, reg_clk_en, reg_blocked}, 4'b0110);

    // Exhaustive sweep: each start state times all 64 input combinations.
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 64; c++) begin
        do_reset();
        case (s)
          1: begin stop_req = 1; xfer_busy = 1; end
          2: begin stop_req = 1; end
          3: begin sw_disable = 1; end
          default: ;
        endcase
        if (s != 0) step();
        check("R2 R5 R9 reach start", pwr_state, s[1:0]);
        st = s[1:0];
        {stop_req, sw_disable, doze_en, doze_in, xfer_busy, frame_done} = c[5:0];
        ex = exp_next(st, c[5], c[4], c[3], c[2], c[1], c[0]);
        step();
        case (ex)
          2'd1: check("R2 next state", pwr_state, ex);
          2'd2: check("R9 next state", pwr_state, ex);
          2'd3: check(c[4] ? "R5 next state" : "R6 next state", pwr_state, ex);
          default: check("R8 next state", pwr_state, ex);
        endcase
        case (ex)
          2'd2: check("R3 outputs", {stop_ack, core_clk_en, reg_clk_en, reg_blocked}, exp_outs(ex));
          2'd3: check("R7 outputs", {stop_ack, core_clk_en, reg_clk_en, reg_blocked}, exp_outs(ex));
          default: check("R1 outputs", {stop_ack, core_clk_en, reg_clk_en, reg_blocked}, exp_outs(ex));
        endcase
      end
    end

    // R2: long pending wait, then boundary.
    do_reset();
    stop_req = 1; xfer_busy = 1;
    for (int k = 0; k < 5; k++) step();
    check("R2 still pending", pwr_state, 2'd1);
    check("R1 no ack while pending", stop_ack, 1'b0);
    frame_done = 1;
    step();
    check("R2 stop at boundary", pwr_state, 2'd2);
    check("R1 ack on stop", stop_ack, 1'b1);

    // R4: freeze of request lines.
    do_reset();
    irq_in = 4'hA; dma_in = 2'b01;
    stop_req = 1;
    step();
    check("R4 irq captured", irq_out, 4'hA);
    check("R4 dma captured", dma_out, 2'b01);
    irq_in = 4'h5; dma_in = 2'b10;
    step();
    check("R4 irq frozen", irq_out, 4'hA);
    check("R4 dma frozen", dma_out, 2'b01);
    stop_req = 0;
    step();
    check("R8 back to run", pwr_state, 2'd0);
    check("R1 ack cleared", stop_ack, 1'b0);
    check("R4 irq follows after exit", irq_out, 4'h5);
    check("R4 dma follows after exit", dma_out, 2'b10);

    // R7: disabled passes requests through.
    do_reset();
    doze_en = 1; doze_in = 1;
    step();
    check("R6 doze disable", pwr_state, 2'd3);
    irq_in = 4'h3; dma_in = 2'b11;
    #1;
    check("R7 irq passthrough", irq_out, 4'h3);
    check("R7 dma passthrough", dma_out, 2'b11);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule